// File: doc/BRIEF.md
# Interrupt Message Delivery Engine

This block converts a bank of interrupt request lines into memory-write interrupt messages. Each input has a routing entry held in an external register file: destination, destination mode, trigger mode, delivery mode, vector, mask, polarity and an in-service flag. When an unmasked input needs service, the engine builds a 64-bit address and a 32-bit data word from that entry. It then offers the pair on a valid/ready port. Pending inputs are served one message at a time, lowest index first.

Level-triggered inputs follow an in-service handshake. When a level message is accepted, the engine commands the register file to set that entry's in-service flag. The input then stays silent until an end-of-interrupt (EOI) broadcast carries a matching vector and the engine commands the flag clear. Edge-triggered inputs send once per rising edge. The engine also drives a per-input delivery-status value, which the register file mirrors.

Top module: `irq_msg_engine`

## Requirements
- R1: The message address has bits 63:32 equal to zero. Bits 31:0 are `addr_base | dest<<12 | 1<<3 | dest_mode<<2`, where all 8 destination bits are used whatever the destination mode.
- R2: The message data is `trig<<15 | in_service<<14 | dlv_mode<<8 | vector`. Trigger encoding is edge=0, level=1. Delivery mode is a 3-bit code passed through unchanged: 000 fixed, 001 lowest, 010 SMI, 011 remote-read, 100 NMI, 101 INIT, 110 startup, 111 external.
- R3: An input whose mask bit is 1 produces no message. A rising edge that arrives while the input is masked is discarded, so clearing the mask later does not send it.
- R4: An edge input (trig=0) sends exactly one message per rising edge of its effective request. Holding the request high produces no further messages.
- R5: A level input (trig=0) ... more precisely, a level input (trig=1) sends while its effective request is high and its in-service input is 0. On the accepting cycle, `rirr_set` has exactly that input's bit set. An accepted edge message sets no bit of `rirr_set`.
- R6: While `eoi_valid` is high, `rirr_clr` has a 1 for every entry with trig=1 whose vector equals `eoi_vec`. Edge entries and entries with other vectors get 0.
- R7: If an EOI matches the entry whose level message is being accepted in the same cycle, that entry gets `rirr_set` and not `rirr_clr`. Other matching entries are still cleared.
- R8: When several inputs are eligible at once, the lowest-indexed one is sent first. The others follow in index order.
- R9: While `msg_valid` is high and `msg_ready` is low, the address and data stay unchanged. After an accepting cycle, `msg_valid` is low for the following cycle.
- R10: `dlv_status[i]` is 1 while input i is eligible and not yet accepted. It is 0 once its message has been accepted.
- R11: The effective request is `irq_req[i] XOR ent_pol[i]`. A falling raw line on an inverted input counts as a rising edge.
- R12: After reset, `msg_valid`, `rirr_set`, `rirr_clr` and `dlv_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N | Raw request line per input |
| ent_pol | input | N | Per-input request inversion |
| ent_mask | input | N | Per-input mask (1 = blocked) |
| ent_trig | input | N | Trigger mode (0 edge, 1 level) |
| ent_rirr | input | N | In-service flag mirrored from the register file |
| ent_dest_log | input | N | Destination mode bit |
| ent_dlv | input | 3*N | Delivery-mode code per input |
| ent_vector | input | 8*N | Vector per input |
| ent_dest | input | 8*N | Destination per input |
| addr_base | input | 32 | Base of the message address |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vec | input | 8 | EOI vector |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| rirr_set | output | N | Set in-service flag command |
| rirr_clr | output | N | Clear in-service flag command |
| dlv_status | output | N | Delivery-status value per input |

## Verification
Two things can fall in the same cycle: accepting a level message, and an EOI broadcast whose vector matches the message's own entry. The bench sets this up with two level inputs that share a vector. The first is sent and accepted, so it holds its in-service flag. The second is then offered, and the EOI is raised in the very cycle `msg_ready` accepts it. The result is judged on both command vectors in that cycle: the accepted entry must appear only in `rirr_set`, and the older entry only in `rirr_clr`.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int VEC_W    = 8;
    localparam int DEST_W   = 8;
    localparam int DLV_W    = 3;
    localparam int LO_AW    = 32;
    localparam int MSG_AW   = 64;
    localparam int DATA_W   = 32;

    localparam int DEST_LSB = 12;
    localparam int HINT_BIT = 3;
    localparam int DLOG_BIT = 2;
    localparam int TRIG_BIT = 15;
    localparam int RIRR_BIT = 14;
    localparam int DLV_LSB  = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef enum logic [DLV_W-1:0] {
        DLV_FIXED  = 3'd0,
        DLV_LOWEST = 3'd1,
        DLV_SMI    = 3'd2,
        DLV_RREAD  = 3'd3,
        DLV_NMI    = 3'd4,
        DLV_INIT   = 3'd5,
        DLV_START  = 3'd6,
        DLV_EXT    = 3'd7
    } dlv_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dest_log;
        trig_e             trig;
        logic              rirr;
        dlv_e              dlv;
        logic [VEC_W-1:0]  vector;
    } route_t;

    typedef struct packed {
        logic [MSG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } msg_t;

    function automatic msg_t build_msg(input route_t r, input logic [LO_AW-1:0] base);
        msg_t             m;
        logic [LO_AW-1:0] lo;
        lo = base
           | (LO_AW'(r.dest) << DEST_LSB)
           | (LO_AW'(1'b1) << HINT_BIT)
           | (LO_AW'(r.dest_log) << DLOG_BIT);
        m.addr = {{(MSG_AW-LO_AW){1'b0}}, lo};
        m.data = (DATA_W'(r.trig) << TRIG_BIT)
               | (DATA_W'(r.rirr) << RIRR_BIT)
               | (DATA_W'(r.dlv) << DLV_LSB)
               | DATA_W'(r.vector);
        return m;
    endfunction

endpackage

// File: rtl/irq_src_track.sv
module irq_src_track (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic pol,
    input  logic mask,
    input  logic trig,
    input  logic rirr,
    input  logic acc,
    output logic elig
);
    logic eff, req_q, pend_q, rise;

    assign eff  = req ^ pol;
    assign rise = eff & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            req_q <= eff;
            if (mask)
                pend_q <= 1'b0;
            else if (rise && !trig)
                pend_q <= 1'b1;
            else if (acc)
                pend_q <= 1'b0;
        end
    end

    assign elig = ~mask & (trig ? (eff & ~rirr) : pend_q);

    // R3: a masked cycle leaves no stored edge behind
    p_mask_drops_edge_r3: assert property (@(posedge clk) disable iff (rst)
        mask |=> !pend_q);

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N = 24,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  elig,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) idx = IW'(i);
        end
    end

    assign any = |elig;

    // R8: the chosen index is one that is actually requesting
    p_pick_is_eligible_r8: assert property (@(posedge clk) disable iff (rst)
        any |-> elig[idx]);

endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match #(
    parameter int N = 24,
    parameter int VW = 8
) (
    input  logic            eoi_valid,
    input  logic [VW-1:0]   eoi_vec,
    input  logic [VW*N-1:0] ent_vector,
    input  logic [N-1:0]    ent_trig,
    input  logic [N-1:0]    keep,
    output logic [N-1:0]    clr
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign clr[i] = eoi_valid & ent_trig[i]
                      & (ent_vector[i*VW +: VW] == eoi_vec) & ~keep[i];
    end
endmodule

// File: rtl/irq_msg_engine.sv
module irq_msg_engine
    import irq_msg_pkg::*;
#(
    parameter int N = 24,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        irq_req,
    input  logic [N-1:0]        ent_pol,
    input  logic [N-1:0]        ent_mask,
    input  logic [N-1:0]        ent_trig,
    input  logic [N-1:0]        ent_rirr,
    input  logic [N-1:0]        ent_dest_log,
    input  logic [DLV_W*N-1:0]  ent_dlv,
    input  logic [VEC_W*N-1:0]  ent_vector,
    input  logic [DEST_W*N-1:0] ent_dest,
    input  logic [LO_AW-1:0]    addr_base,
    input  logic                eoi_valid,
    input  logic [VEC_W-1:0]    eoi_vec,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [MSG_AW-1:0]   msg_addr,
    output logic [DATA_W-1:0]   msg_data,
    output logic [N-1:0]        rirr_set,
    output logic [N-1:0]        rirr_clr,
    output logic [N-1:0]        dlv_status
);
    logic [N-1:0]  elig, acc_vec;
    logic          any, accept, hold_lvl;
    logic [IW-1:0] pick_idx, hold_idx;
    route_t        sel_r;
    msg_t          new_msg, hold_msg;

    assign accept = msg_valid & msg_ready;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign acc_vec[i] = accept & (hold_idx == IW'(i));
        irq_src_track u_trk (
            .clk  (clk),
            .rst  (rst),
            .req  (irq_req[i]),
            .pol  (ent_pol[i]),
            .mask (ent_mask[i]),
            .trig (ent_trig[i]),
            .rirr (ent_rirr[i]),
            .acc  (acc_vec[i]),
            .elig (elig[i])
        );
    end

    irq_lowest_pick #(.N(N)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .elig (elig),
        .any  (any),
        .idx  (pick_idx)
    );

    always_comb begin
        sel_r.dest     = ent_dest[int'(pick_idx)*DEST_W +: DEST_W];
        sel_r.dest_log = ent_dest_log[pick_idx];
        sel_r.trig     = trig_e'(ent_trig[pick_idx]);
        sel_r.rirr     = ent_rirr[pick_idx];
        sel_r.dlv      = dlv_e'(ent_dlv[int'(pick_idx)*DLV_W +: DLV_W]);
        sel_r.vector   = ent_vector[int'(pick_idx)*VEC_W +: VEC_W];
        new_msg        = build_msg(sel_r, addr_base);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            hold_idx  <= '0;
            hold_lvl  <= 1'b0;
            hold_msg  <= '0;
        end else if (accept) begin
            msg_valid <= 1'b0;
        end else if (!msg_valid && any) begin
            msg_valid <= 1'b1;
            hold_idx  <= pick_idx;
            hold_lvl  <= sel_r.trig == TRIG_LEVEL;
            hold_msg  <= new_msg;
        end
    end

    assign msg_addr   = hold_msg.addr;
    assign msg_data   = hold_msg.data;
    assign rirr_set   = acc_vec & {N{hold_lvl}};
    assign dlv_status = elig;

    irq_eoi_match #(.N(N), .VW(VEC_W)) u_eoi (
        .eoi_valid  (eoi_valid),
        .eoi_vec    (eoi_vec),
        .ent_vector (ent_vector),
        .ent_trig   (ent_trig),
        .keep       (rirr_set),
        .clr        (rirr_clr)
    );

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    p_gap_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready |=> !msg_valid);

    p_set_on_level_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (|rirr_set) |-> msg_valid && msg_ready && msg_data[TRIG_BIT]);

    p_set_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rirr_set));

    p_level_sent_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) && msg_data[TRIG_BIT] |-> !msg_data[RIRR_BIT]);

    p_set_beats_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (rirr_set & rirr_clr) == '0);

endmodule

// File: tb/irq_msg_engine_tb_top.sv
`timescale 1ns/1ps
module irq_msg_engine_tb_top;
    localparam int N = 24;
    localparam time CLK_T = 20ns;
    localparam logic [31:0] BASE = 32'hFEE0_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_T/2) clk = ~clk;

    logic [N-1:0]   irq_req = '0, ent_pol = '0, ent_mask = '1, ent_trig = '0, ent_dlog = '0;
    logic [N-1:0]   rf_rirr;
    logic [7:0]     b_vec [N];
    logic [7:0]     b_dest [N];
    logic [2:0]     b_dlv [N];
    logic [3*N-1:0] ent_dlv;
    logic [8*N-1:0] ent_vector, ent_dest;
    logic           eoi_valid = 1'b0, msg_ready = 1'b0;
    logic [7:0]     eoi_vec = '0;
    logic           msg_valid;
    logic [63:0]    msg_addr;
    logic [31:0]    msg_data;
    logic [N-1:0]   rirr_set, rirr_clr, dlv_status;

    int vectors = 0;
    int miscompares = 0;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_vector[i*8 +: 8] = b_vec[i];
            ent_dest[i*8 +: 8]   = b_dest[i];
            ent_dlv[i*3 +: 3]    = b_dlv[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rf_rirr <= '0;
        else     rf_rirr <= (rf_rirr | rirr_set) & ~rirr_clr;
    end

    irq_msg_engine #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .irq_req(irq_req), .ent_pol(ent_pol), .ent_mask(ent_mask),
        .ent_trig(ent_trig), .ent_rirr(rf_rirr), .ent_dest_log(ent_dlog), .ent_dlv(ent_dlv),
        .ent_vector(ent_vector), .ent_dest(ent_dest), .addr_base(BASE),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
        .dlv_status(dlv_status)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic setup(input int i, input logic trig, input logic [7:0] vec,
                         input logic [7:0] dest, input logic dlog, input logic [2:0] dlv);
        ent_trig[i] = trig; b_vec[i] = vec; b_dest[i] = dest;
        ent_dlog[i] = dlog; b_dlv[i] = dlv;
    endtask

    task automatic wait_valid(input int limit, output logic seen);
        seen = 1'b0;
        for (int k = 0; k < limit; k++) begin
            if (msg_valid) begin seen = 1'b1; break; end
            @(negedge clk); #1;
        end
    endtask

    task automatic idle_check(input string tag, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk); #1;
            chk(tag, msg_valid, 1'b0);
        end
    endtask

    task automatic do_accept(input logic with_eoi, input logic [7:0] ev,
                             output logic [N-1:0] s, output logic [N-1:0] c);
        msg_ready = 1'b1; eoi_valid = with_eoi; eoi_vec = ev; #1;
        s = rirr_set; c = rirr_clr;
        @(negedge clk);
        msg_ready = 1'b0; eoi_valid = 1'b0; #1;
    endtask

    task automatic pulse_eoi(input logic [7:0] ev, output logic [N-1:0] c);
        eoi_valid = 1'b1; eoi_vec = ev; #1;
        c = rirr_clr;
        @(negedge clk);
        eoi_valid = 1'b0; #1;
    endtask

    task automatic t_reset();
        chk("R12 valid after reset", msg_valid, 1'b0);
        chk("R12 set after reset", rirr_set, '0);
        chk("R12 clr after reset", rirr_clr, '0);
        chk("R12 status after reset", dlv_status, '0);
    endtask

    task automatic t_edge();
        logic seen; logic [N-1:0] s, c;
        setup(3, 1'b0, 8'h41, 8'hA5, 1'b1, 3'd1);
        ent_mask[3] = 1'b0; irq_req[3] = 1'b1;
        wait_valid(8, seen);
        chk("R4 edge message offered", seen, 1'b1);
        chk("R1 address full dest logical", msg_addr, 64'h0000_0000_FEEA_500C);
        chk("R2 data edge lowest", msg_data, 32'h0000_0141);
        chk("R10 status while offered", dlv_status[3], 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk("R9 held addr", msg_addr, 64'h0000_0000_FEEA_500C);
            chk("R9 held data", msg_data, 32'h0000_0141);
            chk("R9 held valid", msg_valid, 1'b1);
        end
        do_accept(1'b0, 8'h0, s, c);
        chk("R5 edge sets no flag", s, '0);
        chk("R9 gap after accept", msg_valid, 1'b0);
        chk("R10 status cleared", dlv_status[3], 1'b0);
        idle_check("R4 held edge sends once", 6);
        irq_req[3] = 1'b0;
        @(negedge clk);
        irq_req[3] = 1'b1;
        wait_valid(8, seen);
        chk("R4 new edge sends again", seen, 1'b1);
        do_accept(1'b0, 8'h0, s, c);
        irq_req[3] = 1'b0; ent_mask[3] = 1'b1;
    endtask

    task automatic t_level();
        logic seen; logic [N-1:0] s, c;
        setup(5, 1'b1, 8'h52, 8'h3C, 1'b0, 3'd4);
        ent_mask[5] = 1'b0; irq_req[5] = 1'b1;
        wait_valid(8, seen);
        chk("R5 level message offered", seen, 1'b1);
        chk("R1 address physical", msg_addr, 64'h0000_0000_FEE3_C008);
        chk("R2 data level nmi", msg_data, 32'h0000_8452);
        do_accept(1'b0, 8'h0, s, c);
        chk("R5 level sets flag", s, N'(1) << 5);
        idle_check("R5 blocked while in service", 6);
        chk("R10 status blocked", dlv_status[5], 1'b0);
        pulse_eoi(8'h52, c);
        chk("R6 eoi clears level", c, N'(1) << 5);
        wait_valid(8, seen);
        chk("R5 resend after eoi", seen, 1'b1);
        chk("R2 resend data", msg_data, 32'h0000_8452);
        do_accept(1'b0, 8'h0, s, c);
        irq_req[5] = 1'b0;
        pulse_eoi(8'h52, c);
        ent_mask[5] = 1'b1;
    endtask

    task automatic t_eoi_multi();
        logic [N-1:0] c;
        setup(6, 1'b1, 8'h60, 8'h01, 1'b0, 3'd0);
        setup(7, 1'b0, 8'h60, 8'h02, 1'b0, 3'd0);
        setup(8, 1'b1, 8'h61, 8'h03, 1'b0, 3'd0);
        pulse_eoi(8'h60, c);
        chk("R6 only level entries with vector", c, N'(1) << 6);
    endtask

    task automatic t_mask();
        logic seen; logic [N-1:0] s, c;
        setup(9, 1'b0, 8'h69, 8'h09, 1'b0, 3'd0);
        setup(10, 1'b1, 8'h6A, 8'h0A, 1'b0, 3'd0);
        irq_req[9] = 1'b1; irq_req[10] = 1'b1;
        idle_check("R3 masked no message", 6);
        chk("R3 masked status", dlv_status[10:9], 2'b00);
        ent_mask[9] = 1'b0;
        idle_check("R3 masked edge discarded", 6);
        ent_mask[10] = 1'b0;
        wait_valid(8, seen);
        chk("R3 unmasked level sends", seen, 1'b1);
        chk("R3 unmasked vector", msg_data[7:0], 8'h6A);
        do_accept(1'b0, 8'h0, s, c);
        irq_req[9] = 1'b0; irq_req[10] = 1'b0;
        pulse_eoi(8'h6A, c);
        ent_mask[9] = 1'b1; ent_mask[10] = 1'b1;
    endtask

    task automatic t_prio();
        logic seen; logic [N-1:0] s, c;
        setup(11, 1'b1, 8'hB1, 8'h11, 1'b0, 3'd0);
        setup(12, 1'b1, 8'hB2, 8'h12, 1'b0, 3'd0);
        ent_mask[12:11] = 2'b00; irq_req[12:11] = 2'b11;
        wait_valid(8, seen);
        chk("R8 lower index first", msg_data[7:0], 8'hB1);
        do_accept(1'b0, 8'h0, s, c);
        wait_valid(8, seen);
        chk("R8 higher index next", msg_data[7:0], 8'hB2);
        do_accept(1'b0, 8'h0, s, c);
        chk("R5 second level flag", s, N'(1) << 12);
        irq_req[12:11] = 2'b00;
        pulse_eoi(8'hB1, c);
        pulse_eoi(8'hB2, c);
        ent_mask[12:11] = 2'b11;
    endtask

    task automatic t_pol();
        logic seen; logic [N-1:0] s, c;
        setup(13, 1'b0, 8'hC3, 8'h13, 1'b0, 3'd0);
        ent_pol[13] = 1'b1; irq_req[13] = 1'b1;
        @(negedge clk);
        ent_mask[13] = 1'b0;
        idle_check("R11 inverted high is inactive", 4);
        irq_req[13] = 1'b0;
        wait_valid(8, seen);
        chk("R11 falling raw line sends", seen, 1'b1);
        chk("R11 vector", msg_data[7:0], 8'hC3);
        do_accept(1'b0, 8'h0, s, c);
        ent_mask[13] = 1'b1;
    endtask

    task automatic t_collide();
        logic seen; logic [N-1:0] s, c;
        setup(14, 1'b1, 8'h70, 8'h14, 1'b0, 3'd0);
        setup(15, 1'b1, 8'h70, 8'h15, 1'b0, 3'd0);
        ent_mask[15] = 1'b0; irq_req[15] = 1'b1;
        wait_valid(8, seen);
        do_accept(1'b0, 8'h0, s, c);
        irq_req[15] = 1'b0;
        ent_mask[14] = 1'b0; irq_req[14] = 1'b1;
        wait_valid(8, seen);
        chk("R7 entry 14 offered", msg_data[7:0], 8'h70);
        do_accept(1'b1, 8'h70, s, c);
        chk("R7 accepted entry set", s, N'(1) << 14);
        chk("R7 older entry cleared only", c, N'(1) << 15);
        irq_req[14] = 1'b0;
        pulse_eoi(8'h70, c);
        chk("R6 both matching level entries", c, (N'(1) << 14) | (N'(1) << 15));
        ent_mask[15:14] = 2'b11;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            b_vec[i] = 8'hFF; b_dest[i] = '0; b_dlv[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_edge();
        t_level();
        t_eoi_multi();
        t_mask();
        t_prio();
        t_pol();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_T * 100000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule